// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block turns bytes into asynchronous serial characters on a single output line. It is configured at run time through a byte-wide control port. The first control write after reset is a format byte. It selects the character length, the parity, the number of stop bits and the clock multiple. Every later control write is a command byte. Command bytes enable the transmitter, force a break, and drive the two active-low modem-control outputs. A command with its re-arm bit set makes the next control write a format byte again.

Characters enter through a valid/ready stream into a one-deep holding register. A producer holds `tx_valid` and `tx_data` steady until it sees `tx_ready` high at a rising clock edge, and the byte is taken at that edge. `tx_ready` is low while the holding register is occupied. The holding register is emptied when the shifter loads the byte, which happens only while transmission is enabled. Bit timing comes from `baud_tick`, a one-cycle enable pulse that runs at the selected multiple of the bit rate. The format is captured when each character starts, so a later change of format does not affect a character already being sent.

Top module: `prog_uart_tx`

## Requirements
- R1: After reset, `txd`, `rts_n` and `dtr_n` are 1, `stat_txrdy` and `stat_txempty` are 1, `tx_ready` is 1, and the next control write is taken as a format byte.
- R2: The control port decodes writes in a fixed order. A format byte is followed only by command bytes. A command with bit 6 set clears every command control, and the next control write is then taken as a format byte.
- R3: In a command byte, bit 5 = 1 drives `rts_n` to 0 and bit 1 = 1 drives `dtr_n` to 0. The outputs change on the clock after the write.
- R4: Command bit 0 enables transmission. While it is 0, a held byte stays in the holding register and `txd` stays high.
- R5: The data input is a one-byte valid/ready stream. A byte is accepted on a clock edge where both `tx_valid` and `tx_ready` are 1. `tx_ready` is 0 while the holding register is occupied, and the held byte does not change.
- R6: A character is one start bit (0), followed by the data bits LSB first, then the optional parity bit and the stop bits (1). The data length is 5 + the value of format bits 3:2. The line idles at 1.
- R7: Format bit 4 = 1 adds a parity bit computed over the data bits only. Format bit 5 = 1 selects even parity and 0 selects odd parity.
- R8: Format bits 1:0 set the length of each bit in `baud_tick` pulses: 01 gives 1, 10 gives 16, 11 gives 64, and 00 is treated as 01.
- R9: Format bits 7:6 set the stop length: 01 gives 1 bit, 10 gives 1.5 bits (2 bits at the 1-pulse rate, a half bit being half the pulse count otherwise), 11 gives 2 bits, and 00 is treated as 01.
- R10: Command bit 3 = 1 holds `txd` at 0 for as long as it is set.
- R11: `stat_txrdy` is 1 exactly when the holding register is empty. `stat_txempty` is 1 only when the holding register is empty and no character is being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_byte | input | 8 | Format or command byte |
| baud_tick | input | 1 | Bit-timing enable pulse |
| tx_valid | input | 1 | Data byte offered |
| tx_ready | output | 1 | Holding register can take a byte |
| tx_data | input | 8 | Data byte |
| txd | output | 1 | Serial output line |
| rts_n | output | 1 | Request-to-send, active low |
| dtr_n | output | 1 | Terminal-ready, active low |
| stat_txrdy | output | 1 | Holding register empty |
| stat_txempty | output | 1 | Nothing left to send |

## Verification
A wrong format or a wrong decode state shows on `txd` as a character of the wrong length or with the wrong bit level. The first wrong bit appears within one bit time of the character start. The bench records the line level at every `baud_tick` and compares the whole character against a model, so a timing error of a single pulse is detected. A wrong decode state also shows on `rts_n` one clock after the write that follows it. A wrong holding or enable state shows within a few cycles as a mismatch of `tx_ready`, `stat_txrdy` or `stat_txempty`.

// File: rtl/ptx_pkg.sv
package ptx_pkg;
  timeunit 1ns; timeprecision 100ps;

  localparam int MAX_BITS = 8;

  typedef enum logic [2:0] {PH_IDLE, PH_START, PH_DATA, PH_PAR, PH_STOP} phase_t;

  // format byte, bit 7 down to bit 0
  typedef struct packed {
    logic [1:0] stop;
    logic       even;
    logic       par_en;
    logic [1:0] len;
    logic [1:0] fact;
  } fmt_t;

  // command controls the transmitter acts on
  typedef struct packed {
    logic rts;
    logic brk;
    logic dtr;
    logic tx_en;
  } ctl_t;

  function automatic int unsigned tick_mult(logic [1:0] code, int unsigned fast, int unsigned slow);
    case (code)
      2'b10:   return fast;
      2'b11:   return slow;
      default: return 1;
    endcase
  endfunction

  function automatic int unsigned stop_ticks(logic [1:0] code, int unsigned mult);
    case (code)
      2'b10:   return (mult == 1) ? 2 : mult + mult / 2;
      2'b11:   return 2 * mult;
      default: return mult;
    endcase
  endfunction
endpackage

// File: rtl/ptx_ctrl.sv
module ptx_ctrl
  import ptx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic [7:0] ctrl_byte,
  output fmt_t       fmt,
  output ctl_t       ctl,
  output logic       want_fmt
);
  timeunit 1ns; timeprecision 100ps;

  localparam int REARM_BIT = 6;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      want_fmt <= 1'b1;
      fmt      <= '0;
      ctl      <= '0;
    end else if (ctrl_wr) begin
      if (want_fmt) begin
        fmt      <= fmt_t'(ctrl_byte);
        want_fmt <= 1'b0;
      end else if (ctrl_byte[REARM_BIT]) begin
        ctl      <= '0;
        want_fmt <= 1'b1;
      end else begin
        ctl.rts   <= ctrl_byte[5];
        ctl.brk   <= ctrl_byte[3];
        ctl.dtr   <= ctrl_byte[1];
        ctl.tx_en <= ctrl_byte[0];
      end
    end
  end

  // R2
  fmt_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && want_fmt |=> !want_fmt);

  // R2
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && !want_fmt && ctrl_byte[REARM_BIT] |=> want_fmt && ctl == '0);
endmodule

// File: rtl/ptx_hold.sv
module ptx_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  input  logic         take,
  output logic         full,
  output logic [W-1:0] data
);
  timeunit 1ns; timeprecision 100ps;

  assign in_ready = !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (in_valid && in_ready) begin
      full <= 1'b1;
      data <= in_data;
    end else if (take) begin
      full <= 1'b0;
    end
  end

  // R5
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full && !take |=> full && $stable(data));

  // R5
  take_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> full);
endmodule

// File: rtl/ptx_shift.sv
module ptx_shift
  import ptx_pkg::*;
#(
  parameter int FAST_DIV = 16,
  parameter int SLOW_DIV = 64,
  localparam int CNT_W = $clog2(2 * SLOW_DIV + 1),
  localparam int LEFT_W = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  fmt_t                fmt,
  input  logic                tx_en,
  input  logic                hold_full,
  input  logic [MAX_BITS-1:0] hold_data,
  output logic                take,
  output logic                busy,
  output logic                line
);
  timeunit 1ns; timeprecision 100ps;

  phase_t              ph;
  logic [CNT_W-1:0]    cnt, bit_len, stop_len, cur_len;
  logic [MAX_BITS-1:0] sh, mask;
  logic [LEFT_W-1:0]   left, nbits;
  logic                par_bit, par_on;
  int unsigned         mult;

  always_comb begin
    mult  = tick_mult(fmt.fact, FAST_DIV, SLOW_DIV);
    nbits = LEFT_W'(5 + int'(fmt.len));
    mask  = {MAX_BITS{1'b1}} >> (2'd3 - fmt.len);
  end

  assign take    = (ph == PH_IDLE) && hold_full && tx_en;
  assign busy    = (ph != PH_IDLE);
  assign cur_len = (ph == PH_STOP) ? stop_len : bit_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      cnt      <= '0;
      bit_len  <= CNT_W'(1);
      stop_len <= CNT_W'(1);
      sh       <= '0;
      left     <= '0;
      par_bit  <= 1'b0;
      par_on   <= 1'b0;
    end else if (take) begin
      ph       <= PH_START;
      cnt      <= '0;
      sh       <= hold_data & mask;
      left     <= nbits;
      par_bit  <= (^(hold_data & mask)) ^ ~fmt.even;
      par_on   <= fmt.par_en;
      bit_len  <= CNT_W'(mult);
      stop_len <= CNT_W'(stop_ticks(fmt.stop, mult));
    end else if (busy && tick) begin
      if (cnt == cur_len - 1'b1) begin
        cnt <= '0;
        case (ph)
          PH_START: ph <= PH_DATA;
          PH_DATA: begin
            sh   <= sh >> 1;
            left <= left - 1'b1;
            if (left == LEFT_W'(1)) ph <= par_on ? PH_PAR : PH_STOP;
          end
          PH_PAR:  ph <= PH_STOP;
          default: ph <= PH_IDLE;
        endcase
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    case (ph)
      PH_START: line = 1'b0;
      PH_DATA:  line = sh[0];
      PH_PAR:   line = par_bit;
      default:  line = 1'b1;
    endcase
  end

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_IDLE) && !tx_en |=> ph == PH_IDLE);

  // R8
  phase_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !tick |=> $stable(ph));

  // R6
  load_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !line);
endmodule

// File: rtl/prog_uart_tx.sv
module prog_uart_tx
  import ptx_pkg::*;
#(
  parameter int FAST_DIV = 16,
  parameter int SLOW_DIV = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic [7:0] ctrl_byte,
  input  logic       baud_tick,
  input  logic       tx_valid,
  output logic       tx_ready,
  input  logic [7:0] tx_data,
  output logic       txd,
  output logic       rts_n,
  output logic       dtr_n,
  output logic       stat_txrdy,
  output logic       stat_txempty
);
  timeunit 1ns; timeprecision 100ps;

  fmt_t                fmt;
  ctl_t                ctl;
  logic                want_fmt, hold_full, take, busy, line;
  logic [MAX_BITS-1:0] hold_data;

  ptx_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_byte(ctrl_byte),
    .fmt(fmt), .ctl(ctl), .want_fmt(want_fmt)
  );

  ptx_hold #(.W(MAX_BITS)) u_hold (
    .clk(clk), .rst_n(rst_n), .in_valid(tx_valid), .in_data(tx_data),
    .in_ready(tx_ready), .take(take), .full(hold_full), .data(hold_data)
  );

  ptx_shift #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .fmt(fmt), .tx_en(ctl.tx_en),
    .hold_full(hold_full), .hold_data(hold_data), .take(take), .busy(busy),
    .line(line)
  );

  assign txd          = ctl.brk ? 1'b0 : line;
  assign rts_n        = ~ctl.rts;
  assign dtr_n        = ~ctl.dtr;
  assign stat_txrdy   = !hold_full;
  assign stat_txempty = !hold_full && !busy;

  // R3
  rts_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && !want_fmt && !ctrl_byte[6] |=> rts_n == !$past(ctrl_byte[5]));

  // R3
  dtr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && !want_fmt && !ctrl_byte[6] |=> dtr_n == !$past(ctrl_byte[1]));

  // R11
  empty_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !stat_txempty);
endmodule

// File: tb/test_prog_uart_tx.sv
module test_prog_uart_tx;
  timeunit 1ns; timeprecision 100ps;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_wr = 1'b0;
  logic [7:0] ctrl_byte = '0;
  logic       baud_tick;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] tx_data = '0;
  logic       txd, rts_n, dtr_n, stat_txrdy, stat_txempty;

  prog_uart_tx i_prog_uart_tx (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_byte(ctrl_byte),
    .baud_tick(baud_tick), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .txd(txd), .rts_n(rts_n), .dtr_n(dtr_n),
    .stat_txrdy(stat_txrdy), .stat_txempty(stat_txempty)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  // tick every second cycle
  logic tcnt = 1'b0;
  always @(posedge clk) tcnt <= ~tcnt;
  assign baud_tick = tcnt;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      done = 1;
      check(0, "watchdog", cyc, 0);
      finish_run();
    end
  end

  // reference model of a character, one level per tick
  function automatic int fac(logic [7:0] m);
    case (m[1:0]) 2'b10: return 16; 2'b11: return 64; default: return 1; endcase
  endfunction
  function automatic int stop_t(logic [7:0] m);
    int f = fac(m);
    case (m[7:6]) 2'b10: return (f == 1) ? 2 : f + f / 2; 2'b11: return 2 * f; default: return f; endcase
  endfunction
  function automatic int frame_len(logic [7:0] m);
    return fac(m) * (1 + 5 + int'(m[3:2]) + int'(m[4])) + stop_t(m);
  endfunction
  function automatic logic exp_level(logic [7:0] m, logic [7:0] d, int pos);
    int f = fac(m);
    int nd = 5 + int'(m[3:2]);
    int p;
    logic par = 1'b0;
    for (int i = 0; i < nd; i++) par ^= d[i];
    if (!m[5]) par = ~par;
    if (pos < f) return 1'b0;
    p = pos - f;
    if (p < nd * f) return d[p / f];
    p -= nd * f;
    if (m[4]) begin
      if (p < f) return par;
    end
    return 1'b1;
  endfunction

  logic [7:0] q_data[256];
  logic [7:0] q_mode[256];
  int wr_i = 0, rd_i = 0;
  bit mon_en = 1;
  logic [7:0] cur_mode = '0;
  bit expect_fmt = 1;

  // line monitor: R6 R7 R8 R9
  initial begin
    bit inf = 0, bad = 0;
    int pos = 0;
    logic [7:0] m = '0, d = '0;
    forever begin
      @(negedge clk);
      if (mon_en && baud_tick) begin
        if (!inf && txd == 1'b0) begin
          inf = 1; pos = 0; bad = 0;
          m = q_mode[rd_i[7:0]]; d = q_data[rd_i[7:0]];
        end
        if (inf) begin
          if (txd !== exp_level(m, d, pos)) bad = 1;
          pos++;
          if (pos == frame_len(m)) begin
            check(!bad && rd_i < wr_i, "R6 R7 R8 R9 frame", int'(d), int'(m));
            rd_i++;
            inf = 0;
          end
        end
      end
    end
  end

  task automatic ctrl_write(input logic [7:0] b);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_byte = b;
    @(negedge clk); ctrl_wr = 1'b0;
    if (expect_fmt) expect_fmt = 0;
    else if (b[6]) expect_fmt = 1;
  endtask

  task automatic reprogram(input logic [7:0] m);
    if (!expect_fmt) ctrl_write(8'h40);
    ctrl_write(m);
    cur_mode = m;
    ctrl_write(8'h01);
  endtask

  task automatic push(input logic [7:0] b);
    q_data[wr_i[7:0]] = b; q_mode[wr_i[7:0]] = cur_mode; wr_i++;
    @(negedge clk); tx_valid = 1'b1; tx_data = b;
    while (!tx_ready) @(negedge clk);
    @(negedge clk); tx_valid = 1'b0;
  endtask

  task automatic wait_empty();
    @(negedge clk);
    while (!stat_txempty) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [7:0] dir_modes[5] = '{8'h00, 8'hB9, 8'hBE, 8'hD3, 8'h7F};
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(txd && rts_n && dtr_n, "R1 lines", {txd, rts_n, dtr_n}, 3'b111);
    check(stat_txrdy && stat_txempty && tx_ready, "R1 status", {stat_txrdy, stat_txempty, tx_ready}, 3'b111);

    // R1 R2: first write is format, then commands
    ctrl_write(8'h4E); cur_mode = 8'h4E;
    ctrl_write(8'h22);
    // R3
    check(!rts_n && !dtr_n, "R3 rts dtr low", {rts_n, dtr_n}, 0);
    ctrl_write(8'h02);
    check(rts_n && !dtr_n, "R3 rts only released", {rts_n, dtr_n}, 2'b10);

    // R4 R5 R11: held while disabled
    push(8'hA5);
    repeat (100) @(negedge clk);
    check(txd, "R4 line idle when disabled", txd, 1);
    check(!tx_ready && !stat_txrdy && !stat_txempty, "R5 R11 held",
          {tx_ready, stat_txrdy, stat_txempty}, 0);
    ctrl_write(8'h01);
    repeat (3) @(negedge clk);
    check(stat_txrdy && tx_ready && !stat_txempty, "R11 shifting", {stat_txrdy, tx_ready, stat_txempty}, 3'b110);
    wait_empty();
    check(stat_txempty && txd, "R11 empty after frame", {stat_txempty, txd}, 2'b11);

    // R8 R9: directed corner formats
    foreach (dir_modes[i]) begin
      reprogram(dir_modes[i]);
      push(8'($urandom));
      wait_empty();
    end

    // R2: re-arm and format decode
    ctrl_write(8'h20);
    check(!rts_n, "R2 command applied", rts_n, 0);
    ctrl_write(8'h40);
    check(rts_n && dtr_n, "R2 re-arm clears controls", {rts_n, dtr_n}, 2'b11);
    ctrl_write(8'h22); cur_mode = 8'h22;
    check(rts_n && dtr_n, "R2 byte taken as format", {rts_n, dtr_n}, 2'b11);
    ctrl_write(8'h21);
    check(!rts_n && dtr_n, "R2 next is command", {rts_n, dtr_n}, 2'b01);
    push(8'h3C);
    wait_empty();

    // R10: break
    mon_en = 0;
    ctrl_write(8'h09);
    repeat (5) @(negedge clk);
    check(!txd, "R10 break low", txd, 0);
    ctrl_write(8'h01);
    repeat (5) @(negedge clk);
    check(txd, "R10 break released", txd, 1);
    mon_en = 1;

    // random formats, some back to back
    for (int it = 0; it < 24; it++) begin
      reprogram(8'($urandom) & 8'hBF | 8'h00);
      push(8'($urandom));
      if (it % 2 == 0) begin
        push(8'($urandom));
        @(negedge clk);
        // R5
        check(!tx_ready && !stat_txrdy, "R5 second byte held", {tx_ready, stat_txrdy}, 0);
      end
      wait_empty();
    end

    // R6: every frame seen
    check(rd_i == wr_i, "R6 frame count", rd_i, wr_i);
    done = 1;
    finish_run();
  end
endmodule